// File: doc/BRIEF.md
# Fixed-Point Frequency Multiplier Rescaler

This block scales a 38-bit unsigned fixed-point multiplier by the ratio of a new output frequency to the current one. The multiplier has a 10-bit integer part above a 28-bit fraction. The block is used when a synthesizer's fractional multiplier must be recomputed for a retuned output rate.

Both frequencies enter as unsigned integers in the same unit, such as Hz. A pulse on the start input latches the operands. The block then forms the full-width product of the multiplier and the new frequency, and divides that product by the current frequency with a restoring divider that resolves one quotient bit per cycle.

Along with the new multiplier, the block reports two flags. The first says whether the quotient overflowed the 38-bit word. The second says whether the relative change stays inside a ±3500 ppm window. That window separates a glitch-free retune from one that needs the oscillator recalibrated.

Top module: `freq_rescale`

## Requirements
- R1: When it fits in 38 bits, result_o equals floor(mult_i × f_new_i / f_cur_i), computed with no loss of precision before the division. With f_new_i equal to f_cur_i, it returns mult_i unchanged.
- R2: An operand of 0x8858199E9 scaled from 148 350 000 to 148 500 000 yields 0x887B6473C, with in_window_o set.
- R3: When the exact quotient is 2^38 or more, overflow_o is 1 and result_o is all ones. A zero f_cur_i counts as overflow.
- R4: in_window_o is 1 exactly when |f_new_i − f_cur_i| × 1 000 000 ≤ 3500 × f_cur_i, so both ±3500 ppm boundaries are inside the window.
- R5: done_o is high for exactly one cycle. It rises on the 39th rising clock edge after the edge that sampled start_i while the unit was idle.
- R6: A start_i pulse that arrives while a computation is in progress is ignored. It neither changes that computation's results nor produces an extra done_o pulse.
- R7: result_o, overflow_o and in_window_o change only in the cycle where done_o is high. Between done_o pulses they hold their values regardless of the inputs.
- R8: After reset, done_o, result_o, overflow_o and in_window_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Latch operands and begin, when idle |
| mult_i | input | 38 | Current multiplier, 10.28 unsigned fixed point |
| f_cur_i | input | 32 | Current output frequency |
| f_new_i | input | 32 | Requested output frequency |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 38 | Rescaled multiplier, 10.28 fixed point |
| overflow_o | output | 1 | Quotient exceeded 38 bits; result saturated |
| in_window_o | output | 1 | Change within ±3500 ppm |

## Verification
On every cycle, the bound checker enforces the following:
- the single-cycle done pulse and its fixed distance from the accepted start;
- saturation of the result whenever overflow is reported;
- the rule that all three results move only with done.

The numerical content needs the bench's sweeps. These cover the exact quotient, the overflow threshold at 2^38 and at a zero divisor, and the inclusive ppm boundaries on both sides. The same goes for showing that a start issued mid-computation leaves the running result intact.

// File: rtl/rescale_pkg.sv
package rescale_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WRAP} rsc_state_e;
endpackage

// File: rtl/rsc_window.sv
module rsc_window #(
  parameter int FREQ_W    = 32,
  parameter int PPM_LIMIT = 3500,
  parameter int PPM_SCALE = 1000000
) (
  input  logic [FREQ_W-1:0] f_cur_i,
  input  logic [FREQ_W-1:0] f_new_i,
  output logic              in_win_o
);
  localparam int SCALE_W = $clog2(PPM_SCALE + 1);
  localparam int CMP_W   = FREQ_W + SCALE_W;

  logic [FREQ_W-1:0] delta;
  logic [CMP_W-1:0]  lhs, rhs;

  always_comb begin
    delta    = (f_new_i >= f_cur_i) ? (f_new_i - f_cur_i) : (f_cur_i - f_new_i);
    lhs      = CMP_W'(delta) * CMP_W'(PPM_SCALE);
    rhs      = CMP_W'(f_cur_i) * CMP_W'(PPM_LIMIT);
    in_win_o = (lhs <= rhs);
  end
endmodule

// File: rtl/rsc_divider.sv
module rsc_divider #(
  parameter int NUM_W = 38,
  parameter int DEN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [DEN_W-1:0] hi_i,
  input  logic [NUM_W-1:0] lo_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quot_o
);
  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] acc_q;
  logic [DEN_W:0]   trial;
  logic             fit;
  logic [DEN_W-1:0] rem_n;

  // remainder shifted left with the next dividend bit
  always_comb begin
    trial = {rem_q, acc_q[NUM_W-1]};
    fit   = (trial >= {1'b0, den_q});
    rem_n = fit ? (trial[DEN_W-1:0] - den_q) : trial[DEN_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      den_q <= '0;
      acc_q <= '0;
    end else if (load_i) begin
      rem_q <= hi_i;
      den_q <= den_i;
      acc_q <= lo_i;
    end else if (step_i) begin
      rem_q <= rem_n;
      acc_q <= {acc_q[NUM_W-2:0], fit};
    end
  end

  assign quot_o = acc_q;
endmodule

// File: rtl/freq_rescale.sv
module freq_rescale
  import rescale_pkg::*;
#(
  parameter int MULT_W    = 38,
  parameter int FREQ_W    = 32,
  parameter int PPM_LIMIT = 3500,
  parameter int PPM_SCALE = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [FREQ_W-1:0] f_cur_i,
  input  logic [FREQ_W-1:0] f_new_i,
  output logic              done_o,
  output logic [MULT_W-1:0] result_o,
  output logic              overflow_o,
  output logic              in_window_o
);
  localparam int PROD_W = MULT_W + FREQ_W;
  localparam int CNT_W  = $clog2(MULT_W + 1);

  rsc_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FREQ_W-1:0] fcur_q, fnew_q;
  logic              ovf_q, busy, accept, win;
  logic [PROD_W-1:0] prod;
  logic [MULT_W-1:0] quot;

  assign busy   = (state_q != ST_IDLE);
  assign accept = start_i && !busy;
  assign prod   = PROD_W'(mult_i) * PROD_W'(f_new_i);

  rsc_divider #(.NUM_W(MULT_W), .DEN_W(FREQ_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .step_i (state_q == ST_RUN),
    .hi_i   (prod[PROD_W-1:MULT_W]),
    .lo_i   (prod[MULT_W-1:0]),
    .den_i  (f_cur_i),
    .quot_o (quot)
  );

  rsc_window #(.FREQ_W(FREQ_W), .PPM_LIMIT(PPM_LIMIT), .PPM_SCALE(PPM_SCALE)) u_win (
    .f_cur_i  (fcur_q),
    .f_new_i  (fnew_q),
    .in_win_o (win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      fcur_q      <= '0;
      fnew_q      <= '0;
      ovf_q       <= 1'b0;
      done_o      <= 1'b0;
      result_o    <= '0;
      overflow_o  <= 1'b0;
      in_window_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          fcur_q  <= f_cur_i;
          fnew_q  <= f_new_i;
          // quotient fits MULT_W bits only if the high product part is below the divisor
          ovf_q   <= (prod[PROD_W-1:MULT_W] >= f_cur_i);
          cnt_q   <= CNT_W'(MULT_W);
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= ST_WRAP;
        end
        ST_WRAP: begin
          result_o    <= ovf_q ? '1 : quot;
          overflow_o  <= ovf_q;
          in_window_o <= win;
          done_o      <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int MULT_W = 38
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              ovf_i,
  input logic              win_i,
  input logic [MULT_W-1:0] result_i
);
  localparam int LAT   = MULT_W + 2;
  localparam int LAT_W = $clog2(MULT_W + 4) + 1;

  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lat_q <= '0;
    else if (start_i && !busy_i) lat_q <= LAT_W'(1);
    else if (done_i)            lat_q <= '0;
    else if (lat_q != '0)       lat_q <= lat_q + 1'b1;
  end

  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (lat_q == LAT_W'(LAT)));
  a_r3_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ovf_i) |-> (&result_i));
  a_r7_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_i) |-> done_i);
  a_r7_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ovf_i) || !$stable(win_i)) |-> done_i);
endmodule

bind freq_rescale rsc_checker #(.MULT_W(MULT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_i   (busy),
  .done_i   (done_o),
  .ovf_i    (overflow_o),
  .win_i    (in_window_o),
  .result_i (result_o)
);

// File: tb/freq_rescale_test.sv
`timescale 1ns/1ps
module freq_rescale_test;
  localparam int MW  = 38;
  localparam int FW  = 32;
  localparam int LAT = MW + 2;  // negedges counted from the drive edge until done is seen

  logic          clk = 0, rst_n = 0, start = 0;
  logic [MW-1:0] mult = '0;
  logic [FW-1:0] fcur = '0, fnew = '0;
  logic          done, ovf, win;
  logic [MW-1:0] res;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  freq_rescale uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mult_i(mult),
    .f_cur_i(fcur), .f_new_i(fnew), .done_o(done), .result_o(res),
    .overflow_o(ovf), .in_window_o(win)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_of(input logic [MW-1:0] m, input logic [FW-1:0] fc, input logic [FW-1:0] fn,
                           output logic [MW-1:0] er, output logic eo, output logic ew);
    logic [127:0] p, q, d;
    p = 128'(m) * 128'(fn);
    if (fc == 0) eo = 1'b1;
    else begin
      q  = p / 128'(fc);
      eo = (q >= (128'd1 << MW));
      er = q[MW-1:0];
    end
    if (eo) er = '1;
    d  = (fn >= fc) ? 128'(fn - fc) : 128'(fc - fn);
    ew = (d * 128'd1000000) <= (128'(fc) * 128'd3500);
  endtask

  // poke: at cycle 10 pulse start with different operands (must be ignored)
  task automatic run(input logic [MW-1:0] m, input logic [FW-1:0] fc, input logic [FW-1:0] fn,
                     input string req, input bit poke);
    logic [MW-1:0] er; logic eo, ew; int c;
    expect_of(m, fc, fn, er, eo, ew);
    @(negedge clk); start = 1; mult = m; fcur = fc; fnew = fn;
    @(negedge clk); start = 0; c = 1;
    while (!done && c < 200) begin
      if (poke && c == 10) begin start = 1; mult = ~m; fcur = fc + 3; fnew = fn + 7; end
      else start = 0;
      @(negedge clk); c++;
    end
    start = 0;
    check({req, " R5 latency"}, 128'(c), 128'(LAT));
    check({req, " result"}, 128'(res), 128'(er));
    check({req, " overflow"}, 128'(ovf), 128'(eo));
    check({req, " window"}, 128'(win), 128'(ew));
    @(negedge clk);
    check("R5 done one cycle", 128'(done), 128'd0);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [MW-1:0] pats [4];
    logic [MW-1:0] held;
    int dcount;
    pats[0] = 38'h1; pats[1] = 38'h2A_AAAA_AAAA; pats[2] = 38'h1F_FFFF_FFFF; pats[3] = '1;
    repeat (3) @(negedge clk);
    check("R8 reset done", 128'(done), 0);
    check("R8 reset result", 128'(res), 0);
    check("R8 reset overflow", 128'(ovf), 0);
    check("R8 reset window", 128'(win), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 worked example
    run(38'h8858199E9, 32'd148_350_000, 32'd148_500_000, "R2", 0);
    check("R2 literal", 128'(res), 128'h887B6473C);
    check("R2 window", 128'(win), 1);

    // R1 identity
    run(38'h8858199E9, 32'd156_250_000, 32'd156_250_000, "R1 identity", 0);
    check("R1 identity literal", 128'(res), 128'h8858199E9);
    run(38'h7FA611E85, 32'd156_250_000, 32'd161_132_813, "R1 large change", 0);

    // R4 inclusive boundaries
    run(38'h10000000, 32'd1_000_000, 32'd1_003_500, "R4 upper edge", 0);
    check("R4 upper in", 128'(win), 1);
    run(38'h10000000, 32'd1_000_000, 32'd1_003_501, "R4 upper out", 0);
    check("R4 upper out", 128'(win), 0);
    run(38'h10000000, 32'd1_000_000, 32'd996_500, "R4 lower edge", 0);
    check("R4 lower in", 128'(win), 1);
    run(38'h10000000, 32'd1_000_000, 32'd996_499, "R4 lower out", 0);
    check("R4 lower out", 128'(win), 0);

    // R3 overflow threshold
    run(38'h20_0000_0000, 32'd1, 32'd2, "R3 exactly 2^38", 0);
    check("R3 ovf at 2^38", 128'(ovf), 1);
    run(38'h20_0000_0000, 32'd2, 32'd3, "R3 below", 0);
    check("R3 no ovf", 128'(ovf), 0);
    run('1, 32'd5, 32'd5, "R3 all ones fits", 0);
    run(38'h123, 32'd0, 32'd9, "R3 zero divisor", 0);
    check("R3 zero div ovf", 128'(ovf), 1);

    // R6 start ignored while busy
    run(38'h8858199E9, 32'd148_350_000, 32'd148_500_000, "R6 poke", 1);
    check("R6 result unchanged", 128'(res), 128'h887B6473C);
    // R7 outputs hold; R6 no extra done
    held = res; dcount = 0;
    mult = ~held; fcur = 32'd7; fnew = 32'd99;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (done) dcount++; end
    check("R6 no extra done", 128'(dcount), 0);
    check("R7 result held", 128'(res), 128'(held));
    check("R7 window held", 128'(win), 1);

    // R1/R3/R4 sweep over small frequencies
    for (int p = 0; p < 4; p++)
      for (int fc = 0; fc < 10; fc++)
        for (int fn = 0; fn < 10; fn++)
          run(pats[p], FW'(fc), FW'(fn), "R1 R3 R4 sweep", 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule